// File: doc/BRIEF.md
# Single-Port Memory Bit-Vector Rotator

This block rotates a long bit vector held in a word-wide single-port memory by one bit position toward the higher indices. It does so in place, one memory access per clock cycle. Vector bit `i` lives in word `i / 32` at bit `i % 32`, so a vector of `VEC_BITS` bits fills `ceil(VEC_BITS/32)` words, and the top word may be only partly used.

The memory is assumed to behave in read-first fashion. During a cycle that writes an address, the read data port shows that address's contents from before the write. The rotator uses this in two phases. First it makes one read-only access to the top word to pick up the bit that wraps from the vector's highest position into position 0. It then sweeps the words upward, writing each one back as its own old value shifted left by one. The carry into bit 0 comes from bit 31 of the word below. Unused bits of the top word are forced to zero.

A host pulses `start` to request one rotation and sees `done` for one cycle when the memory holds the rotated vector. Operations can be chained back to back by raising `start` in the `done` cycle.

Top module: `bitvec_rotator`

## Requirements
- R1: A vector of VEC_BITS bits is held in WORDS = ceil(VEC_BITS/32) words of 32 bits, with vector bit i at word i/32, bit i%32. Word addresses 0 to WORDS-1 are the only ones ever driven.
- R2: After one operation, vector bit i (for i ≥ 1) holds the old bit i-1, and vector bit 0 holds the old bit VEC_BITS-1.
- R3: An operation uses WORDS+1 memory cycles. In the first cycle after `start` is sampled, the address is WORDS-1 with write enable low. Then come WORDS cycles with write enable high at addresses 0, 1, …, WORDS-1 in ascending order.
- R4: When VEC_BITS is not a multiple of 32, the wrapping bit is taken from bit (VEC_BITS-1)%32 of the top word, and all bits above that position in the top word are written as zero.
- R5: `done` is high for exactly one cycle, the cycle right after the last write. At all other times it is low.
- R6: A `start` pulse that arrives while an operation is in progress is ignored. It changes neither the timing nor the result of the running operation, and it does not queue a second one.
- R7: A `start` raised in the cycle where `done` is high is accepted and begins a new operation.
- R8: While reset is asserted and after it is released, write enable and `done` are low until a `start` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one rotation (taken only when idle) |
| memAddr | output | ADDR_BITS | Word address for the single memory port |
| memRdata | input | 32 | Read data; during a write cycle it holds the address's old contents |
| memWdata | output | 32 | Write data |
| memWe | output | 1 | Write enable |
| done | output | 1 | One-cycle pulse after the last write of an operation |

## Verification
The rotation is tried with several vector patterns, each of which catches a different kind of fault:
- A lone bit at position 0 checks the simple shift within a word.
- A lone bit at position 31 shows whether the carry crosses a word boundary.
- A lone bit at the top position shows whether the wrap bit is taken from the right bit of the partial word.
- An all-ones vector shows whether the padding bits stay zero.
- Alternating and irregular patterns separate a rotation by one from a rotation by any other amount after several chained operations.

Separate directed runs cover reset, a stray `start` during the sweep, and back-to-back starts issued in the `done` cycle.

// File: rtl/bitvec_rot_pkg.sv
package bitvec_rot_pkg;
  localparam int WORD_BITS = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SWEEP = 2'd2
  } rotState_t;

  typedef struct packed {
    logic capWrap;   // capture the wrap bit from the top word
    logic shiftWord; // sweep step: shift the word and pass its carry on
    logic lastWord;  // current sweep step targets the partial top word
  } rotStrobes_t;
endpackage

// File: rtl/bitvec_rot_ctrl.sv
module bitvec_rot_ctrl
  import bitvec_rot_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int ADDR_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic [ADDR_BITS-1:0] memAddr,
  output logic                 memWe,
  output rotStrobes_t          strobes,
  output logic                 done
);
  localparam logic [ADDR_BITS-1:0] TOP_ADDR = ADDR_BITS'(WORDS - 1);

  rotState_t state;
  logic [ADDR_BITS-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) state <= ST_FETCH;
        end
        ST_FETCH: begin
          idx   <= '0;
          state <= ST_SWEEP;
        end
        ST_SWEEP: begin
          if (idx == TOP_ADDR) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    memAddr = '0;
    memWe   = 1'b0;
    strobes = '0;
    unique case (state)
      ST_FETCH: begin
        memAddr         = TOP_ADDR;
        strobes.capWrap = 1'b1;
      end
      ST_SWEEP: begin
        memAddr           = idx;
        memWe             = 1'b1;
        strobes.shiftWord = 1'b1;
        strobes.lastWord  = (idx == TOP_ADDR);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitvec_rot_dpath.sv
module bitvec_rot_dpath
  import bitvec_rot_pkg::*;
#(
  parameter int VEC_BITS = 100,
  parameter int WORDS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rotStrobes_t          strobes,
  input  logic [WORD_BITS-1:0] memRdata,
  output logic [WORD_BITS-1:0] memWdata
);
  localparam int WRAP_POS   = (VEC_BITS - 1) % WORD_BITS;
  localparam int LAST_VALID = VEC_BITS - (WORDS - 1) * WORD_BITS;

  logic carry;
  logic [WORD_BITS-1:0] lastMask;
  logic [WORD_BITS-1:0] shifted;

  generate
    if (LAST_VALID == WORD_BITS) begin : g_full_top
      assign lastMask = '1;
    end else begin : g_part_top
      assign lastMask = {{(WORD_BITS - LAST_VALID){1'b0}}, {LAST_VALID{1'b1}}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carry <= 1'b0;
    end else if (strobes.capWrap) begin
      carry <= memRdata[WRAP_POS];
    end else if (strobes.shiftWord) begin
      carry <= memRdata[WORD_BITS-1];
    end
  end

  assign shifted  = {memRdata[WORD_BITS-2:0], carry};
  assign memWdata = strobes.lastWord ? (shifted & lastMask) : shifted;
endmodule

// File: rtl/bitvec_rotator.sv
module bitvec_rotator
  import bitvec_rot_pkg::*;
#(
  parameter int VEC_BITS = 4801,
  parameter int WORDS = (VEC_BITS + WORD_BITS - 1) / WORD_BITS,
  parameter int ADDR_BITS = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic [ADDR_BITS-1:0] memAddr,
  input  logic [WORD_BITS-1:0] memRdata,
  output logic [WORD_BITS-1:0] memWdata,
  output logic                 memWe,
  output logic                 done
);
  rotStrobes_t strobes;

  bitvec_rot_ctrl #(.WORDS(WORDS), .ADDR_BITS(ADDR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .memAddr(memAddr), .memWe(memWe), .strobes(strobes), .done(done)
  );

  bitvec_rot_dpath #(.VEC_BITS(VEC_BITS), .WORDS(WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .memRdata(memRdata), .memWdata(memWdata)
  );
endmodule

// File: rtl/bitvec_rotator_chk.sv
module bitvec_rotator_chk #(
  parameter int VEC_BITS = 4801,
  parameter int WORDS = 151,
  parameter int ADDR_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_BITS-1:0] memAddr,
  input logic [31:0]          memRdata,
  input logic [31:0]          memWdata,
  input logic                 memWe,
  input logic                 done
);
  localparam int LAST_VALID = VEC_BITS - (WORDS - 1) * 32;
  localparam logic [31:0] PAD_BITS =
    (LAST_VALID == 32) ? 32'h0 : ~((32'h1 << LAST_VALID) - 32'h1);

  // R1: the address never leaves the vector's word range
  a_r1_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    32'(memAddr) < WORDS);

  // R3: the first write of a sweep targets word 0
  a_r3_first_write_zero: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !$past(memWe)) |-> memAddr == '0);

  // R3: consecutive writes climb by one address
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> 32'(memAddr) == 32'($past(memAddr)) + 1);

  // R2: carry into bit 0 of word k comes from bit 31 of old word k-1
  a_r2_carry_chain: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> memWdata[0] == $past(memRdata[31]));

  // R4: padding bits of the top word are written as zero
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && 32'(memAddr) == WORDS - 1) |-> (memWdata & PAD_BITS) == 32'h0);

  // R5: done follows the last write and lasts one cycle
  a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(memWe) && !memWe));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind bitvec_rotator bitvec_rotator_chk #(
  .VEC_BITS(VEC_BITS), .WORDS(WORDS), .ADDR_BITS(ADDR_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdata(memRdata),
  .memWdata(memWdata), .memWe(memWe), .done(done)
);

// File: tb/tb_bitvec_rotator.sv
`timescale 1ns/1ps
module tb_bitvec_rotator;
  localparam int R  = 100;
  localparam int W  = (R + 31) / 32;
  localparam int AB = (W > 1) ? $clog2(W) : 1;
  localparam int NPAT = 6;

  // stimulus table: initial vector and number of chained rotations
  localparam logic [R-1:0] PAT [NPAT] = '{
    100'h1,
    100'h8000_0000,
    {1'b1, 99'h0},
    {R{1'b1}},
    {25{4'b1010}},
    100'h9_3C5A_0F1E_DEAD_BEEF_1234_5678
  };
  localparam int ROTS [NPAT] = '{1, 1, 1, 2, 3, 5};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AB-1:0] memAddr;
  logic [31:0] memRdata, memWdata;
  logic memWe, done;

  logic [31:0] mem [W];
  logic loadEn = 1'b0;
  logic [AB-1:0] loadAddr = '0;
  logic [31:0] loadData = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [R-1:0] refVec;

  always #2.5 clk = ~clk;

  // read-first single-port memory model
  assign memRdata = mem[memAddr];
  always_ff @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
    else if (memWe) mem[memAddr] <= memWdata;
  end

  bitvec_rotator #(.VEC_BITS(R)) dut (
    .clk(clk), .rstN(rstN), .start(start), .memAddr(memAddr),
    .memRdata(memRdata), .memWdata(memWdata), .memWe(memWe), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refWord(input logic [R-1:0] v, input int k);
    logic [32*W-1:0] padded;
    padded = {{(32*W-R){1'b0}}, v};
    return padded[32*k +: 32];
  endfunction

  task automatic loadVec(input logic [R-1:0] v);
    for (int k = 0; k < W; k++) begin
      loadEn = 1'b1; loadAddr = AB'(k); loadData = refWord(v, k);
      @(negedge clk);
    end
    loadEn = 1'b0;
  endtask

  // one rotation; start is already high on entry. strayAt>=0 pulses start mid-sweep
  task automatic runOp(input int strayAt);
    int cnt;
    @(negedge clk);
    start = 1'b0;
    check(memWe == 1'b0 && 32'(memAddr) == W - 1, "R3 fetch cycle",
          {memWe, 31'(memAddr)}, 32'(W - 1));
    cnt = 0;
    while (!done && cnt < 4 * W + 8) begin
      @(negedge clk);
      if (!done) begin
        if (memWe != 1'b1 || 32'(memAddr) != cnt)
          check(1'b0, "R3 sweep address", 32'(memAddr), 32'(cnt));
        start = (cnt == strayAt); // R6 stray start during sweep
      end
      cnt++;
    end
    start = 1'b0;
    check(cnt == W + 1, "R5 done timing", 32'(cnt), 32'(W + 1));
    refVec = {refVec[R-2:0], refVec[R-1]};
  endtask

  task automatic compareMem(input string req);
    for (int k = 0; k < W; k++)
      check(mem[k] == refWord(refVec, k), req, mem[k], refWord(refVec, k));
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    refVec = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(memWe == 1'b0 && done == 1'b0, "R8 reset outputs", {memWe, done}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(memWe == 1'b0 && done == 1'b0, "R8 idle after reset", {memWe, done}, 32'h0);

    // table walk: R1 R2 R4 R7 (chained starts raised in the done cycle)
    for (int p = 0; p < NPAT; p++) begin
      loadVec(PAT[p]);
      refVec = PAT[p];
      start = 1'b1;
      for (int n = 0; n < ROTS[p]; n++) begin
        runOp(-1);
        if (n < ROTS[p] - 1) start = 1'b1; // R7 start while done is high
      end
      compareMem("R2 R4 rotated vector");
      @(negedge clk);
      check(done == 1'b0, "R5 done one cycle", {31'h0, done}, 32'h0);
    end

    // R4: top bit wraps into bit 0, padding zero
    loadVec({1'b1, 99'h0});
    refVec = {1'b1, 99'h0};
    start = 1'b1;
    runOp(-1);
    check(mem[0] == 32'h1, "R4 wrap bit", mem[0], 32'h1);
    check(mem[W-1] == 32'h0, "R4 top word cleared", mem[W-1], 32'h0);

    // R6: stray start mid-sweep, no second operation follows
    loadVec(PAT[5]);
    refVec = PAT[5];
    start = 1'b1;
    runOp(1);
    repeat (3) begin
      @(negedge clk);
      check(memWe == 1'b0, "R6 no queued op", {31'h0, memWe}, 32'h0);
    end
    compareMem("R6 single rotation");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule